// File: doc/BRIEF.md
# Octal DAC Serial Register Controller

This block is the digital front end of an eight-channel, 16-bit voltage-output converter. A host writes 32-bit frames over a three-wire serial link: a frame-select line held low, a serial clock, and a data line. The block decodes each frame into a command, a channel address and a 16-bit code, and keeps two registers per channel. The staging register takes new values. The output register drives the analog converter. A staged value reaches the output only on an explicit update command, on a falling edge of the hardware load pin, or at the end of a write while the load pin is held low.

Besides the code path, the block keeps a two-bit power-down mode per channel, an internal-reference enable, a per-channel load override mask and a selectable clear code. An active-low clear input forces every output register to that code. All serial and pin inputs are oversampled by the system clock through synchronizers, so the whole block runs on one clock.

Top module: `octal_dac_frontend`

## Requirements
- R1: A frame is 32 bits, most significant bit first, with the data line sampled on falling edges of the serial clock while frame-select is low. It takes effect only after the 32nd falling edge. Field positions: command in bits 27..24, address in 23..20, code in 19..4. Bits 31..28 and 3..0 are ignored by the code-write commands.
- R2: If frame-select rises before 32 bits have arrived, the frame is dropped and no output or state changes.
- R3: Command 0 writes the staging register of the addressed channel and leaves its output unchanged unless R7 applies. Address 15 selects every channel. Addresses 8 to 14 select none.
- R4: Command 1 copies the staging register into the output register of the addressed channel(s). Command 3 writes both registers of the addressed channel(s) with the code.
- R5: Command 2 writes the staging register of the addressed channel(s) and then loads every channel's output register from its staging register.
- R6: A falling edge on the load pin (ldac_n) copies all staging registers into all output registers.
- R7: When a frame with command 0 to 3 completes, every channel whose load-override bit is set, or every channel if ldac_n is low, loads its output register from its staging register. Command 6 sets the override mask from frame bits 7..0, where bit i is channel i.
- R8: While clr_n is low, every output code is forced to the clear code, and staging registers are untouched. Command 5 selects the clear code from frame bits 1..0: 0 gives 0x0000, 1 gives 0x8000, 2 gives 0xFFFF, and 3 leaves the selection unchanged.
- R9: After reset, all codes equal the reset code (0x0000 by default, 0x8000 when RESET_TO_MID is set). All power-down modes are 0, the reference is off, the clear code is zero scale and the override mask is clear.
- R10: Command 4 sets the power-down mode to frame bits 9..8 on every channel i whose frame bit i (7..0) is set. Channel i's mode appears on pd_mode[2i+1:2i].
- R11: Command 8 sets ref_en to frame bit 0. No other input turns the reference on.
- R12: Command 7 returns every register to its reset state. Commands 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sync_n | input | 1 | Frame select, low while a frame is shifted in |
| sclk | input | 1 | Serial clock; data sampled on its falling edge |
| din | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Load pin; falling edge or low level releases staged codes |
| clr_n | input | 1 | Active-low clear to the selected clear code |
| dac_code | output | 16*N_CH | Output register codes, channel i at bits [16i+15:16i] |
| pd_mode | output | 2*N_CH | Power-down mode per channel, 0 = normal |
| ref_en | output | 1 | Internal reference enable |

## Verification
Random frames mix the four code-write commands with random addresses, including the broadcast value and the unused addresses 8 to 14. This separates staging-only writes from output updates and single-channel from all-channel selection. Load-pin pulses, held-low load frames and random override masks are interleaved so that a design that confuses the edge, level and mask paths leaves a different code on some channel. Clear pulses are followed by an update-all frame, so a clear that corrupts staging registers becomes visible. Directed cases cover a truncated frame, clear selection 3, reserved commands and the soft reset.

// File: rtl/octal_dac_pkg.sv
package octal_dac_pkg;

  localparam int CODE_W  = 16;
  localparam int FRAME_W = 32;
  localparam int ADDR_W  = 4;

  typedef enum logic [3:0] {
    CMD_WR_IN       = 4'd0,
    CMD_UPD         = 4'd1,
    CMD_WR_UPD_ALL  = 4'd2,
    CMD_WR_UPD_ONE  = 4'd3,
    CMD_PWRDN       = 4'd4,
    CMD_CLR_CODE    = 4'd5,
    CMD_LOAD_MASK   = 4'd6,
    CMD_SOFT_RESET  = 4'd7,
    CMD_REF         = 4'd8
  } cmd_e;

  typedef struct packed {
    logic [3:0]        pad_hi;
    logic [3:0]        cmd;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
    logic [3:0]        pad_lo;
  } frame_t;

  // Code forced by the clear pin for a given selection.
  function automatic logic [CODE_W-1:0] clear_value(input logic [1:0] sel);
    case (sel)
      2'd0:    return '0;
      2'd1:    return {1'b1, {(CODE_W-1){1'b0}}};
      default: return '1;
    endcase
  endfunction

  // Address 15 is broadcast; otherwise exact match.
  function automatic logic chan_hit(input logic [ADDR_W-1:0] addr,
                                    input logic [ADDR_W-1:0] idx);
    return (addr == '1) || (addr == idx);
  endfunction

  function automatic logic is_code_write(input logic [3:0] cmd);
    return cmd <= 4'(CMD_WR_UPD_ONE);
  endfunction

endpackage

// File: rtl/octal_dac_sync.sv
module octal_dac_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/octal_dac_serial_rx.sv
module octal_dac_serial_rx #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_n,
  input  logic               sclk,
  input  logic               din,
  output logic               frame_valid,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic       sync_s, sclk_s, din_s, sclk_prev;
  logic [2:0] pins_s;

  octal_dac_sync #(.W(3), .STAGES(2), .RST_VAL(3'b110)) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sync_n, sclk, din}),
    .q    (pins_s)
  );
  assign {sync_s, sclk_s, din_s} = pins_s;

  logic               sclk_fall, in_frame, last_bit;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shift_q;

  assign sclk_fall = sclk_prev & ~sclk_s;
  assign in_frame  = ~sync_s;
  assign last_bit  = (bit_cnt == CNT_W'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev   <= 1'b1;
      bit_cnt     <= '0;
      shift_q     <= '0;
      frame_valid <= 1'b0;
      frame_word  <= '0;
    end else begin
      sclk_prev   <= sclk_s;
      frame_valid <= 1'b0;
      if (!in_frame) begin
        bit_cnt <= '0;
      end else if (sclk_fall && bit_cnt != CNT_W'(FRAME_W)) begin
        shift_q <= {shift_q[FRAME_W-2:0], din_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (last_bit) begin
          frame_valid <= 1'b1;
          frame_word  <= {shift_q[FRAME_W-2:0], din_s};
        end
      end
    end
  end
endmodule

// File: rtl/octal_dac_decode.sv
module octal_dac_decode
  import octal_dac_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic               ldac_low,
  input  logic [N_CH-1:0]    load_mask,
  output logic [N_CH-1:0]    wr_in,
  output logic [N_CH-1:0]    upd,
  output logic [CODE_W-1:0]  wr_data,
  output logic               pd_we,
  output logic [1:0]         pd_mode_new,
  output logic [N_CH-1:0]    pd_sel,
  output logic               clr_we,
  output logic [1:0]         clr_sel_new,
  output logic               mask_we,
  output logic [N_CH-1:0]    mask_new,
  output logic               soft_rst,
  output logic               ref_we,
  output logic               ref_new
);
  frame_t f;
  assign f = frame_t'(frame_word);

  logic c_wr, c_upd, c_all, c_one, c_codewr;
  assign c_wr     = frame_valid && f.cmd == CMD_WR_IN;
  assign c_upd    = frame_valid && f.cmd == CMD_UPD;
  assign c_all    = frame_valid && f.cmd == CMD_WR_UPD_ALL;
  assign c_one    = frame_valid && f.cmd == CMD_WR_UPD_ONE;
  assign c_codewr = frame_valid && is_code_write(f.cmd);

  assign wr_data = f.code;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic hit;
    assign hit      = chan_hit(f.addr, ADDR_W'(i));
    assign wr_in[i] = hit && (c_wr || c_all || c_one);
    assign upd[i]   = (hit && (c_upd || c_one)) || c_all
                      || (c_codewr && (ldac_low || load_mask[i]));
  end

  assign pd_we       = frame_valid && f.cmd == CMD_PWRDN;
  assign pd_mode_new = frame_word[9:8];
  assign pd_sel      = frame_word[N_CH-1:0];

  assign clr_we      = frame_valid && f.cmd == CMD_CLR_CODE && frame_word[1:0] != 2'd3;
  assign clr_sel_new = frame_word[1:0];

  assign mask_we     = frame_valid && f.cmd == CMD_LOAD_MASK;
  assign mask_new    = frame_word[N_CH-1:0];

  assign soft_rst    = frame_valid && f.cmd == CMD_SOFT_RESET;

  assign ref_we      = frame_valid && f.cmd == CMD_REF;
  assign ref_new     = frame_word[0];
endmodule

// File: rtl/octal_dac_channels.sv
module octal_dac_channels #(
  parameter int                N_CH       = 8,
  parameter int                CODE_W     = 16,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH-1:0]          wr_in,
  input  logic [N_CH-1:0]          upd,
  input  logic [CODE_W-1:0]        wr_data,
  input  logic                     soft_rst,
  input  logic                     ldac_fall,
  input  logic                     clr_act,
  input  logic [CODE_W-1:0]        clr_code,
  output logic [N_CH*CODE_W-1:0]   codes
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [CODE_W-1:0] stage_q, out_q, stage_next;

    assign stage_next = wr_in[i] ? wr_data : stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= RESET_CODE;
        out_q   <= RESET_CODE;
      end else begin
        if (soft_rst) stage_q <= RESET_CODE;
        else          stage_q <= stage_next;

        if (clr_act)                out_q <= clr_code;
        else if (soft_rst)          out_q <= RESET_CODE;
        else if (ldac_fall || upd[i]) out_q <= stage_next;
      end
    end

    assign codes[i*CODE_W +: CODE_W] = out_q;
  end
endmodule

// File: rtl/octal_dac_frontend.sv
module octal_dac_frontend
  import octal_dac_pkg::*;
#(
  parameter int N_CH         = 8,
  parameter bit RESET_TO_MID = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sync_n,
  input  logic                   sclk,
  input  logic                   din,
  input  logic                   ldac_n,
  input  logic                   clr_n,
  output logic [N_CH*CODE_W-1:0] dac_code,
  output logic [2*N_CH-1:0]      pd_mode,
  output logic                   ref_en
);
  localparam logic [CODE_W-1:0] RESET_CODE = RESET_TO_MID ? clear_value(2'd1) : clear_value(2'd0);

  // Named internal events
  logic               frame_valid;
  logic [FRAME_W-1:0] frame_word;
  logic               ldac_s, clr_s, ldac_prev;
  logic               ldac_fall, ldac_low, clr_act;
  logic [1:0]         clr_sel;
  logic [N_CH-1:0]    load_mask;

  octal_dac_serial_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_n     (sync_n),
    .sclk       (sclk),
    .din        (din),
    .frame_valid(frame_valid),
    .frame_word (frame_word)
  );

  octal_dac_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ldac_n, clr_n}),
    .q    ({ldac_s, clr_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldac_prev <= 1'b1;
    else        ldac_prev <= ldac_s;
  end

  assign ldac_fall = ldac_prev & ~ldac_s;
  assign ldac_low  = ~ldac_s;
  assign clr_act   = ~clr_s;

  logic [N_CH-1:0]   wr_in, upd, pd_sel, mask_new;
  logic [CODE_W-1:0] wr_data;
  logic              pd_we, clr_we, mask_we, soft_rst, ref_we, ref_new;
  logic [1:0]        pd_mode_new, clr_sel_new;

  octal_dac_decode #(.N_CH(N_CH)) u_dec (
    .frame_valid(frame_valid),
    .frame_word (frame_word),
    .ldac_low   (ldac_low),
    .load_mask  (load_mask),
    .wr_in      (wr_in),
    .upd        (upd),
    .wr_data    (wr_data),
    .pd_we      (pd_we),
    .pd_mode_new(pd_mode_new),
    .pd_sel     (pd_sel),
    .clr_we     (clr_we),
    .clr_sel_new(clr_sel_new),
    .mask_we    (mask_we),
    .mask_new   (mask_new),
    .soft_rst   (soft_rst),
    .ref_we     (ref_we),
    .ref_new    (ref_new)
  );

  octal_dac_channels #(.N_CH(N_CH), .CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_chan (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_in    (wr_in),
    .upd      (upd),
    .wr_data  (wr_data),
    .soft_rst (soft_rst),
    .ldac_fall(ldac_fall),
    .clr_act  (clr_act),
    .clr_code (clear_value(clr_sel)),
    .codes    (dac_code)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_pd
    logic [1:0] mode_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mode_q <= 2'd0;
      else if (soft_rst)           mode_q <= 2'd0;
      else if (pd_we && pd_sel[i]) mode_q <= pd_mode_new;
    end
    assign pd_mode[2*i +: 2] = mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_sel   <= 2'd0;
      load_mask <= '0;
      ref_en    <= 1'b0;
    end else if (soft_rst) begin
      clr_sel   <= 2'd0;
      load_mask <= '0;
      ref_en    <= 1'b0;
    end else begin
      if (clr_we)  clr_sel   <= clr_sel_new;
      if (mask_we) load_mask <= mask_new;
      if (ref_we)  ref_en    <= ref_new;
    end
  end
endmodule

// File: rtl/octal_dac_frontend_chk.sv
module octal_dac_frontend_chk
  import octal_dac_pkg::*;
#(
  parameter int N_CH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frame_valid,
  input logic                   ldac_fall,
  input logic                   clr_act,
  input logic [1:0]             clr_sel,
  input logic [N_CH*CODE_W-1:0] dac_code,
  input logic [2*N_CH-1:0]      pd_mode,
  input logic                   ref_en
);
  // R1
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R2
  dac_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> $past(frame_valid || ldac_fall || clr_act));

  // R10
  pd_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_mode) |-> $past(frame_valid));

  // R11
  ref_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_en) |-> $past(frame_valid));

  for (genvar i = 0; i < N_CH; i++) begin : g_clr
    // R8
    clear_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_act && !frame_valid) |=> dac_code[i*CODE_W +: CODE_W] == clear_value($past(clr_sel)));
  end
endmodule

bind octal_dac_frontend octal_dac_frontend_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/octal_dac_frontend_test.sv
module octal_dac_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, sync_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic ldac_n = 1'b1, clr_n = 1'b1;
  logic [N*16-1:0] dac_code;
  logic [2*N-1:0]  pd_mode;
  logic            ref_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  octal_dac_frontend #(.N_CH(N)) uut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .din(din),
    .ldac_n(ldac_n), .clr_n(clr_n), .dac_code(dac_code), .pd_mode(pd_mode), .ref_en(ref_en)
  );

  // Reference model
  logic [15:0] m_in [N];
  logic [15:0] m_out[N];
  logic [1:0]  m_pd [N];
  logic        m_ref, m_ldac_low;
  logic [1:0]  m_clr;
  logic [7:0]  m_mask;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  function automatic logic [15:0] clr_code_of(input logic [1:0] s);
    if (s == 2'd0) return 16'h0000;
    if (s == 2'd1) return 16'h8000;
    return 16'hFFFF;
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] cmd, input logic [3:0] addr,
                                     input logic [15:0] code, input logic [3:0] lo);
    return {4'($urandom), cmd, addr, code, lo};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_in[i] = 16'h0000; m_out[i] = 16'h0000; m_pd[i] = 2'd0;
    end
    m_ref = 1'b0; m_clr = 2'd0; m_mask = 8'h00;
  endtask

  task automatic model_frame(input logic [31:0] w);
    logic [3:0] cmd;
    logic [3:0] addr;
    cmd = w[27:24]; addr = w[23:20];
    for (int i = 0; i < N; i++) begin
      bit sel;
      sel = (addr == 4'hF) || (addr == 4'(i));
      case (cmd)
        4'd0: if (sel) m_in[i] = w[19:4];
        4'd1: if (sel) m_out[i] = m_in[i];
        4'd2: begin if (sel) m_in[i] = w[19:4]; end
        4'd3: if (sel) begin m_in[i] = w[19:4]; m_out[i] = w[19:4]; end
        4'd4: if (w[i]) m_pd[i] = w[9:8];
        default: ;
      endcase
    end
    if (cmd == 4'd2) for (int i = 0; i < N; i++) m_out[i] = m_in[i];
    if (cmd == 4'd5 && w[1:0] != 2'd3) m_clr = w[1:0];
    if (cmd == 4'd6) m_mask = w[7:0];
    if (cmd == 4'd7) model_reset();
    if (cmd == 4'd8) m_ref = w[0];
    if (cmd <= 4'd3)
      for (int i = 0; i < N; i++) if (m_ldac_low || m_mask[i]) m_out[i] = m_in[i];
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int nbits);
    wait_clk(1);
    sync_n = 1'b0;
    wait_clk(HALF);
    for (int b = 0; b < nbits; b++) begin
      din = w[31-b];
      wait_clk(HALF);
      sclk = 1'b0;
      wait_clk(HALF);
      sclk = 1'b1;
    end
    wait_clk(2);
    sync_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic send(input logic [31:0] w);
    shift_bits(w, 32);
    model_frame(w);
  endtask

  task automatic ldac_pulse();
    ldac_n = 1'b0; wait_clk(6);
    ldac_n = 1'b1; wait_clk(6);
    for (int i = 0; i < N; i++) m_out[i] = m_in[i];
  endtask

  task automatic clear_pulse();
    clr_n = 1'b0; wait_clk(6);
    clr_n = 1'b1; wait_clk(6);
    for (int i = 0; i < N; i++) m_out[i] = clr_code_of(m_clr);
  endtask

  task automatic held_load_frame(input logic [31:0] w);
    ldac_n = 1'b0; wait_clk(6);
    for (int i = 0; i < N; i++) m_out[i] = m_in[i];
    m_ldac_low = 1'b1;
    send(w);
    ldac_n = 1'b1; m_ldac_low = 1'b0;
    wait_clk(6);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) begin
      check(req, $sformatf("code ch%0d", i), 32'(dac_code[i*16 +: 16]), 32'(m_out[i]));
      check(req, $sformatf("pd ch%0d", i), 32'(pd_mode[2*i +: 2]), 32'(m_pd[i]));
    end
    check(req, "ref_en", 32'(ref_en), 32'(m_ref));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    m_ldac_low = 1'b0;
    model_reset();
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check_all("R9");

    // R1: MSB-first decode, write-and-update on channel 2
    send({4'hA, 4'd3, 4'd2, 16'h1234, 4'h5});
    check_all("R1");
    // R3: staging only, then broadcast and unused address
    send(mk(4'd0, 4'd5, 16'hBEEF, 4'h0));
    check_all("R3");
    send(mk(4'd0, 4'hF, 16'h0F0F, 4'h0));
    check_all("R3");
    send(mk(4'd3, 4'd9, 16'h7777, 4'h0));
    check_all("R3");
    // R4: update one channel from staging
    send(mk(4'd1, 4'd5, 16'h0000, 4'h0));
    check_all("R4");
    // R2: truncated frame dropped
    shift_bits({4'h0, 4'd3, 4'hF, 16'hDEAD, 4'h0}, 20);
    check_all("R2");
    shift_bits({4'h0, 4'd8, 4'h0, 16'h0000, 4'h1}, 31);
    check_all("R2");
    // R5
    send(mk(4'd2, 4'd0, 16'hCAFE, 4'h0));
    check_all("R5");
    // R6
    send(mk(4'd0, 4'hF, 16'h4321, 4'h0));
    ldac_pulse();
    check_all("R6");
    // R7: held load pin and override mask
    held_load_frame(mk(4'd0, 4'd3, 16'h5A5A, 4'h0));
    check_all("R7");
    send(mk(4'd6, 4'h0, 16'h0000, 4'h2) | 32'h0000_0012);
    send(mk(4'd0, 4'hF, 16'h9999, 4'h0));
    check_all("R7");
    // R8: clear codes, selection 3 keeps full scale
    send(mk(4'd5, 4'h0, 16'h0000, 4'h2));
    send(mk(4'd5, 4'h0, 16'h0000, 4'h3));
    clear_pulse();
    check_all("R8");
    send(mk(4'd1, 4'hF, 16'h0000, 4'h0));
    check_all("R8");
    // R10, R11
    send(mk(4'd4, 4'h0, 16'h0020, 4'h5) | 32'h0000_0200);
    check_all("R10");
    send(mk(4'd8, 4'h0, 16'h0000, 4'h1));
    check_all("R11");
    // R12: reserved commands then soft reset
    send(mk(4'd12, 4'hF, 16'hFFFF, 4'hF));
    check_all("R12");
    send(mk(4'd7, 4'h0, 16'h0000, 4'h0));
    check_all("R12");

    // Random mix
    for (int n = 0; n < 160; n++) begin
      int r;
      r = int'($urandom % 20);
      if (r < 12) begin
        send(mk(4'($urandom % 4), 4'($urandom), 16'($urandom), 4'($urandom)));
        check_all("R3 R4 R5");
      end else if (r == 12) begin
        send(mk(4'd4, 4'($urandom), 16'($urandom), 4'($urandom)));
        check_all("R10");
      end else if (r == 13) begin
        send(mk(4'd5, 4'($urandom), 16'($urandom), 4'($urandom)));
        check_all("R8");
      end else if (r == 14) begin
        logic [31:0] w;
        w = mk(4'd6, 4'($urandom), 16'($urandom), 4'($urandom));
        if ($urandom % 2 == 0) w[7:0] = 8'h00;
        send(w);
        check_all("R7");
      end else if (r == 15) begin
        send(mk(4'd8, 4'($urandom), 16'($urandom), 4'($urandom)));
        check_all("R11");
      end else if (r == 16) begin
        send(mk(4'(9 + $urandom % 7), 4'($urandom), 16'($urandom), 4'($urandom)));
        check_all("R12");
      end else if (r == 17) begin
        ldac_pulse();
        check_all("R6");
      end else if (r == 18) begin
        clear_pulse();
        check_all("R8");
      end else begin
        held_load_frame(mk(4'($urandom % 4), 4'($urandom), 16'($urandom), 4'($urandom)));
        check_all("R7");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule